// File: doc/BRIEF.md
# Synchronous Burst Read Latency Controller

This block is the device-side read sequencer of a 32-bit-wide memory that supports both clocked burst reads and plain asynchronous reads. In burst mode the host presents a start address with the active-low address-strobe input. The block captures that address, waits a programmable number of clock cycles, and then places one data word per clock on the bus from an internal word counter. A data-valid indicator tells the host when the bus carries good data.

The word counter drives the address port of the storage array, and the array returns the addressed word on a read-data input. In asynchronous mode the counter is not used. The applied address goes straight to the array and the returned word goes straight to the bus, so the programmed latency plays no part.

The latency comes from a 4-bit configuration field. The field value plus two gives the number of clock cycles, and codes above 7 are treated as the longest setting of nine cycles. Chip enable ends any burst, and output enable only gates the bus drivers.

Top module: `burst_read_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no burst started, `data_valid` is 0. Whenever the bus is not driven, `dq_out` reads 0.
- R2: The initial latency is L = `lat_field` + 2 for codes 0 to 7 and L = 9 for codes 8 to 15. The first word of a burst is on `dq_out`, with `data_valid` high, after the (L-1)th rising clock edge following the start edge, so the host samples it on the Lth edge.
- R3: A burst starts on a rising `clk` edge at which `adv_n` is 0, provided `adv_n` was 1 at the previous edge, `ce_n` is 0 and `sync_mode` is 1. `addr_in` is captured on that edge, and later changes of `addr_in` do not affect the burst.
- R4: While the latency is counting, `data_valid` stays 0 and `mem_addr` holds the captured start address.
- R5: Once streaming, the k-th word on `dq_out` (k = 0, 1, 2, ...) is the array content at start address + k. Words appear on consecutive clock cycles and `data_valid` stays 1.
- R6: The word counter wraps from the all-ones address to 0 and keeps streaming.
- R7: A new start (per R3) during a burst aborts it: `data_valid` is 0 after that edge, and the full latency of the current field is counted again from the new address.
- R8: While `ce_n` is 1, `dq_drive` is 0 at once. `data_valid` is 0 after the next edge, and it stays 0 after `ce_n` returns low until a new start.
- R9: `dq_drive` equals (`ce_n` = 0 and `oe_n` = 0). Raising `oe_n` does not stop or disturb a burst.
- R10: With `sync_mode` = 0, `mem_addr` follows `addr_in` and `dq_out` follows `mem_rdata` combinationally. `data_valid` is 0, `adv_n` starts nothing, and the latency counter stays idle, so returning to `sync_mode` = 1 without a new start gives no data.
- R11: Holding `adv_n` low for several edges gives a single start: the burst streams on without restarting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Burst clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_n | input | 1 | Address strobe, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| sync_mode | input | 1 | 1 = clocked burst reads, 0 = asynchronous reads |
| lat_field | input | LFW (4) | Initial-latency code |
| addr_in | input | AW (16) | Word address from the host |
| mem_rdata | input | DW (32) | Word returned by the array for `mem_addr` |
| mem_addr | output | AW (16) | Word address sent to the array |
| dq_out | output | DW (32) | Data bus value, 0 when not driven |
| dq_drive | output | 1 | Bus driver enable |
| data_valid | output | 1 | High while a burst word is on the bus |

## Verification
If the latency counter is loaded or decremented wrongly, `data_valid` rises one or more cycles early or late on the very first burst. Each code is probed separately, so an off-by-one in the code-to-cycles mapping or in the saturation shows on the first burst that uses the affected code. If the word counter is corrupted, the wrong array word appears within one cycle of launch, and a missed wrap shows at the first crossing of the top address. If the start detector or the abort path is stuck, the old data stream keeps running after a new strobe, or holding the strobe low restarts the burst. Either fault is visible within two cycles through `data_valid` and `dq_out`.

// File: rtl/brl_pkg.sv
package brl_pkg;

  localparam int unsigned BRL_LAT_BASE = 2;

  // Cycles of initial latency for a given configuration code, saturated.
  function automatic int unsigned brl_latency(input int unsigned code,
                                              input int unsigned max_lat);
    int unsigned cyc;
    cyc = code + BRL_LAT_BASE;
    return (cyc > max_lat) ? max_lat : cyc;
  endfunction

endpackage

// File: rtl/brl_start_detect.sv
module brl_start_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_n,
  input  logic arm,
  output logic start
);
  logic adv_seen_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adv_seen_hi <= 1'b1;
    else        adv_seen_hi <= adv_n;
  end

  // First edge of a fresh strobe assertion only.
  assign start = arm & ~adv_n & adv_seen_hi;
endmodule

// File: rtl/brl_latency_cnt.sv
module brl_latency_cnt #(
  parameter int LFW     = 4,
  parameter int MAX_LAT = 9,
  localparam int CW     = $clog2(MAX_LAT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           halt,
  input  logic           start,
  input  logic [LFW-1:0] lat_field,
  output logic           active,
  output logic           launch,
  output logic           lat_wait,
  output logic           valid_q
);
  import brl_pkg::*;

  logic [CW-1:0] remain;
  logic [CW-1:0] load_val;

  assign load_val = CW'(brl_latency(32'(lat_field), MAX_LAT) - 1);
  assign lat_wait = active & (remain > CW'(1));
  assign launch   = active & (remain <= CW'(1)) & ~start & ~halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      remain  <= '0;
      valid_q <= 1'b0;
    end else if (halt) begin
      active  <= 1'b0;
      remain  <= '0;
      valid_q <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      remain  <= load_val;
      valid_q <= 1'b0;
    end else if (launch) begin
      remain  <= '0;
      valid_q <= 1'b1;
    end else if (lat_wait) begin
      remain  <= remain - CW'(1);
    end
  end
endmodule

// File: rtl/brl_addr_seq.sv
module brl_addr_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          advance,
  output logic [AW-1:0] cur_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur_addr <= '0;
    else if (start)   cur_addr <= start_addr;
    else if (advance) cur_addr <= cur_addr + AW'(1);
  end
endmodule

// File: rtl/burst_read_ctrl.sv
module burst_read_ctrl #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int LFW     = 4,
  parameter int MAX_LAT = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv_n,
  input  logic           ce_n,
  input  logic           oe_n,
  input  logic           sync_mode,
  input  logic [LFW-1:0] lat_field,
  input  logic [AW-1:0]  addr_in,
  input  logic [DW-1:0]  mem_rdata,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  dq_out,
  output logic           dq_drive,
  output logic           data_valid
);
  logic          halt;
  logic          burst_start;
  logic          burst_active;
  logic          word_launch;
  logic          lat_wait;
  logic          valid_q;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] dq_q;

  assign halt = ce_n | ~sync_mode;

  brl_start_detect start_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_n (adv_n),
    .arm   (~halt),
    .start (burst_start)
  );

  brl_latency_cnt #(.LFW(LFW), .MAX_LAT(MAX_LAT)) lat_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt),
    .start     (burst_start),
    .lat_field (lat_field),
    .active    (burst_active),
    .launch    (word_launch),
    .lat_wait  (lat_wait),
    .valid_q   (valid_q)
  );

  brl_addr_seq #(.AW(AW)) addr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (burst_start),
    .start_addr (addr_in),
    .advance    (word_launch),
    .cur_addr   (cur_addr)
  );

  // Output word register, loaded on every launched word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           dq_q <= '0;
    else if (word_launch) dq_q <= mem_rdata;
  end

  assign mem_addr   = sync_mode ? cur_addr : addr_in;
  assign dq_drive   = ~ce_n & ~oe_n;
  assign dq_out     = !dq_drive ? '0 : (sync_mode ? dq_q : mem_rdata);
  assign data_valid = valid_q & sync_mode & ~ce_n;
endmodule

// File: rtl/brl_checker.sv
module brl_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          sync_mode,
  input logic          data_valid,
  input logic [AW-1:0] mem_addr,
  input logic          burst_start,
  input logic          burst_active,
  input logic          lat_wait
);
  AST_CE_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !data_valid); // R8

  AST_RESTART_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> !data_valid); // R7

  AST_WAIT_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_wait && !ce_n && sync_mode && !burst_start) |=>
      (!data_valid && (!sync_mode || $stable(mem_addr)))); // R4

  AST_STREAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !burst_start) |=>
      (!sync_mode || !data_valid || mem_addr == AW'($past(mem_addr) + 1'b1))); // R5

  AST_ASYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |=> !burst_active); // R10

  AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> !burst_start); // R11
endmodule

bind burst_read_ctrl brl_checker #(.AW(AW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ce_n         (ce_n),
  .sync_mode    (sync_mode),
  .data_valid   (data_valid),
  .mem_addr     (mem_addr),
  .burst_start  (burst_start),
  .burst_active (burst_active),
  .lat_wait     (lat_wait)
);

// File: tb/burst_read_ctrl_tb_top.sv
`timescale 1ns/1ps
module burst_read_ctrl_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          adv_n = 1'b1;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b0;
  logic          sync_mode = 1'b1;
  logic [3:0]    lat_field = 4'd0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] dq_out;
  logic          dq_drive;
  logic          data_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench reference state
  bit            m_prev = 1'b1;
  bit            m_active = 1'b0;
  bit            m_valid = 1'b0;
  int            m_rem = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] dfun(input logic [AW-1:0] a);
    return ({16'h0, a} * 32'h9E3779B1) ^ 32'hC3A50F1E;
  endfunction

  function automatic int exp_lat(input logic [3:0] f);
    return (f > 4'd7) ? 9 : int'(f) + 2;
  endfunction

  assign mem_rdata = dfun(mem_addr);

  burst_read_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .adv_n(adv_n), .ce_n(ce_n), .oe_n(oe_n),
    .sync_mode(sync_mode), .lat_field(lat_field), .addr_in(addr_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .dq_out(dq_out),
    .dq_drive(dq_drive), .data_valid(data_valid)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  // One clock: advance the reference from the inputs held across the edge,
  // then compare registered outputs shortly after the edge.
  task automatic tick();
    bit halt, st;
    halt = ce_n || !sync_mode;
    st   = !adv_n && m_prev && !halt;
    @(posedge clk);
    if (!rst_n) begin
      m_prev = 1'b1; m_active = 1'b0; m_valid = 1'b0; m_rem = 0; m_addr = '0;
    end else begin
      m_prev = adv_n;
      if (halt) begin
        m_active = 1'b0; m_valid = 1'b0; m_rem = 0;
      end else if (st) begin
        m_active = 1'b1; m_valid = 1'b0; m_addr = addr_in;
        m_rem = exp_lat(lat_field) - 1;
      end else if (m_active && m_rem <= 1) begin
        m_valid = 1'b1; m_data = dfun(m_addr); m_addr = m_addr + 1'b1; m_rem = 0;
      end else if (m_active) begin
        m_rem--;
      end
    end
    #2;
    if (rst_n) begin
      chk(data_valid == (m_valid && sync_mode && !ce_n), "R5 valid vs reference",
          64'(data_valid), 64'(m_valid));
      if (sync_mode && m_active)
        chk(mem_addr == m_addr, "R5 word address vs reference", 64'(mem_addr), 64'(m_addr));
      if (sync_mode && m_valid && !ce_n && !oe_n)
        chk(dq_out == m_data, "R5 data vs reference", 64'(dq_out), 64'(m_data));
    end
  endtask

  task automatic start_burst(input logic [AW-1:0] a, input logic [3:0] f);
    adv_n = 1'b1;
    tick();
    adv_n = 1'b0; addr_in = a; lat_field = f;
    tick();
    adv_n = 1'b1; addr_in = ~a;   // later address changes must not matter (R3)
  endtask

  task automatic wait_valid(input logic [AW-1:0] a, output int k);
    k = 0;
    while (!data_valid && k < 20) begin
      chk(mem_addr == a, "R4 address held during latency", 64'(mem_addr), 64'(a));
      tick();
      k++;
    end
  endtask

  task automatic end_burst();
    ce_n = 1'b1;
    #1;
    chk(dq_drive == 1'b0 && dq_out == '0, "R8 bus released on chip disable",
        64'(dq_out), 64'h0);
    tick();
    chk(data_valid == 1'b0, "R8 valid cleared", 64'(data_valid), 64'h0);
    ce_n = 1'b0;
    tick();
    chk(data_valid == 1'b0, "R8 burst stays ended", 64'(data_valid), 64'h0);
  endtask

  initial begin : main
    int k;
    logic [3:0] codes [6] = '{4'd0, 4'd1, 4'd3, 4'd7, 4'd8, 4'd15};
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));

    // R1: reset state
    ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) tick();
    chk(data_valid == 1'b0, "R1 valid low in reset", 64'(data_valid), 64'h0);
    chk(dq_out == '0, "R1 bus zero in reset", 64'(dq_out), 64'h0);
    rst_n = 1'b1;
    repeat (2) tick();
    chk(data_valid == 1'b0, "R1 valid low after reset", 64'(data_valid), 64'h0);
    ce_n = 1'b1; #1;
    chk(dq_out == '0, "R1 undriven bus reads zero", 64'(dq_out), 64'h0);
    ce_n = 1'b0;

    // R2/R3/R4/R5: latency per code, then a run of words
    foreach (codes[i]) begin
      a = AW'($urandom);
      start_burst(a, codes[i]);
      wait_valid(a, k);
      chk(k == exp_lat(codes[i]) - 1, "R2 initial latency", 64'(k),
          64'(exp_lat(codes[i]) - 1));
      chk(dq_out == dfun(a), "R3 first word from captured address", 64'(dq_out),
          64'(dfun(a)));
      for (int w = 1; w < 4; w++) begin
        tick();
        chk(dq_out == dfun(AW'(a + w)) && data_valid, "R5 consecutive word",
            64'(dq_out), 64'(dfun(AW'(a + w))));
      end
      end_burst();
    end

    // R6: wrap at the top of the address space
    start_burst(16'hFFFE, 4'd0);
    wait_valid(16'hFFFE, k);
    tick();
    chk(dq_out == dfun(16'hFFFF), "R6 word before wrap", 64'(dq_out), 64'(dfun(16'hFFFF)));
    chk(mem_addr == 16'h0000, "R6 counter wrapped", 64'(mem_addr), 64'h0);
    tick();
    chk(dq_out == dfun(16'h0000), "R6 word after wrap", 64'(dq_out), 64'(dfun(16'h0000)));
    end_burst();

    // R7: restart during latency and during streaming
    start_burst(16'h1200, 4'd5);
    repeat (3) tick();
    adv_n = 1'b0; addr_in = 16'h3400;
    tick();
    adv_n = 1'b1; addr_in = 16'h0BAD;
    wait_valid(16'h3400, k);
    chk(k == 6, "R7 latency recounted after restart", 64'(k), 64'd6);
    chk(dq_out == dfun(16'h3400), "R7 data from new address", 64'(dq_out),
        64'(dfun(16'h3400)));
    tick();
    adv_n = 1'b0; addr_in = 16'h5600; lat_field = 4'd2;
    tick();
    chk(data_valid == 1'b0, "R7 valid drops on restart", 64'(data_valid), 64'h0);
    adv_n = 1'b1;
    wait_valid(16'h5600, k);
    chk(k == 3, "R7 second restart latency", 64'(k), 64'd3);
    chk(dq_out == dfun(16'h5600), "R7 second restart data", 64'(dq_out),
        64'(dfun(16'h5600)));

    // R9: output enable only gates the drivers
    oe_n = 1'b1; #1;
    chk(dq_drive == 1'b0 && dq_out == '0, "R9 drivers off", 64'(dq_out), 64'h0);
    tick();
    chk(data_valid == 1'b1, "R9 burst continues", 64'(data_valid), 64'h1);
    oe_n = 1'b0; #1;
    chk(dq_out == dfun(16'h5601), "R9 stream undisturbed", 64'(dq_out),
        64'(dfun(16'h5601)));
    end_burst();

    // R11: strobe held low gives one start
    adv_n = 1'b1; tick();
    adv_n = 1'b0; addr_in = 16'h7000; lat_field = 4'd0;
    tick();
    repeat (4) tick();
    chk(data_valid && dq_out == dfun(16'h7003), "R11 no restart while held low",
        64'(dq_out), 64'(dfun(16'h7003)));
    adv_n = 1'b1;
    end_burst();

    // R10: asynchronous mode
    sync_mode = 1'b0; addr_in = 16'h0ACE; #1;
    chk(mem_addr == 16'h0ACE, "R10 address passes through", 64'(mem_addr), 64'h0ACE);
    chk(dq_out == dfun(16'h0ACE) && !data_valid, "R10 data passes through",
        64'(dq_out), 64'(dfun(16'h0ACE)));
    addr_in = 16'hBEEF; #1;
    chk(dq_out == dfun(16'hBEEF), "R10 follows new address", 64'(dq_out),
        64'(dfun(16'hBEEF)));
    adv_n = 1'b0; tick(); adv_n = 1'b1; repeat (2) tick();
    chk(data_valid == 1'b0, "R10 strobe ignored", 64'(data_valid), 64'h0);
    sync_mode = 1'b1;
    repeat (12) tick();
    chk(data_valid == 1'b0, "R10 counter stayed idle", 64'(data_valid), 64'h0);

    // Constrained random traffic against the reference
    for (int n = 0; n < 3000; n++) begin
      adv_n     = ($urandom_range(9) != 0);
      ce_n      = ($urandom_range(39) == 0);
      oe_n      = ($urandom_range(7) == 0);
      sync_mode = ($urandom_range(59) != 0);
      lat_field = 4'($urandom);
      addr_in   = AW'($urandom);
      #1;
      chk(dq_drive == (!ce_n && !oe_n), "R9 driver enable", 64'(dq_drive),
          64'(!ce_n && !oe_n));
      if (!sync_mode && dq_drive)
        chk(dq_out == dfun(addr_in), "R10 async data", 64'(dq_out), 64'(dfun(addr_in)));
      tick();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule